// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block turns a short packet into line states on a low-speed differential bus pair. The packet is either a data packet or a two-byte handshake reply. For a data packet, a byte count is given at start, and the bytes, starting with the sync byte, come in over a valid/ready stream. For a handshake, only the PID is given, and the block supplies the sync byte itself. Each bit lasts a fixed number of clocks (eight at 12 MHz, which gives 1.5 Mbit/s). The bits are NRZI coded, and the block inserts stuffing toggles inline, so the source never sees a stall.

Around the payload, the block takes and releases the bus in a fixed order. The outputs are first preset to the idle state while the drivers are still off. The drivers are then turned on, and the idle state is held for one bit time. The payload follows, then end of packet: two bit times with both lines low, then one bit time of idle. After that, the drivers are turned off and both line outputs go low, so no pull-up stays active. When a data packet (not a handshake) ends, the pending device address becomes the active one.

The stream side has no buffering beyond a one-byte prefetch register. `in_ready` is high only while that register is empty and bytes are still owed. A byte moves on a rising clock edge where both `in_valid` and `in_ready` are high. The source may hold `in_valid` low for a while, but the next byte must be present by the time the bit engine needs it, which is roughly one byte time after the previous transfer. If it is absent, the packet ends there with a normal end of packet.

Top module: `ls_pkt_tx`

## Requirements
- R1: A start accepted on a rising edge turns on the drivers one clock later. The first sync bit appears 9 clocks after acceptance, which is well inside the 60-clock reply window. Every later line slot lasts exactly 8 clocks.
- R2: J is encoded as `line_dp`=0, `line_dm`=1, and K as `line_dp`=1, `line_dm`=0. For the one clock before `line_oe` rises, the outputs already show J. After `line_oe` rises, J is held for one slot before the first bit.
- R3: In data mode, exactly `byte_count` bytes are fetched from the stream. The first of these is the sync byte (0x80, supplied by the source). Every byte is sent LSB first.
- R4: A data bit of 0 toggles the line between J and K. A data bit of 1 leaves the line unchanged.
- R5: After six consecutive 1 bits, one extra toggle slot is inserted before the next data bit. No such slot is added when the run of six ends the packet.
- R6: After the last bit, both lines are driven low for two slots, then J for one slot. After that, `line_oe` is 0 and both line outputs are 0.
- R7: In handshake mode (`hs_mode`=1), the block sends the sync byte 0x80 followed by `hs_pid`, and `in_ready` stays low for the whole packet.
- R8: `dev_addr` takes the value of `pend_addr` at the end of the two low slots of a data packet. A handshake packet leaves `dev_addr` unchanged. `dev_addr` resets to 0.
- R9: `busy` is high from the clock after acceptance until the drivers are released. A `start` that arrives while `busy` is high is ignored.
- R10: `in_ready` is high only while the prefetch register is empty and data bytes are still owed. Gaps in `in_valid` of a few clocks between bytes do not change the line output.
- R11: If the next byte has not arrived when the bit engine needs it, the packet ends after the bytes already sent, with the normal end-of-packet sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate reference clock (8 clocks per bit) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send one packet, accepted when idle |
| hs_mode | input | 1 | 1 = handshake packet, 0 = data packet from the stream |
| hs_pid | input | 8 | PID byte sent in handshake mode |
| byte_count | input | CNT_W | Number of data-mode bytes, including sync |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Block accepts a stream byte this cycle |
| in_data | input | 8 | Stream byte |
| pend_addr | input | ADDR_W | Device address to adopt after a data packet |
| dev_addr | output | ADDR_W | Active device address |
| line_dp | output | 1 | Positive line output value |
| line_dm | output | 1 | Negative line output value |
| line_oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress, bus held |

## Verification
Some properties are checked on every clock by assertions. Acquisition always shows J first. A stuffing slot always flips the line. The prefetch byte stays put while it is full and not consumed. The engine never consumes an empty buffer. A start while busy never changes the latched mode. The address only moves at the end of a data packet's low period. What the assertions cannot show is the whole symbol sequence: NRZI against the bytes, where stuffing falls, the exact slot lengths, the idle slot after the low period, and truncation when the stream runs dry. These come only from the bench's scenarios. A reference model computes each expected slot from the bytes, and a monitor compares every slot on the line.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h80;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRESET,
    PH_ACQ,
    PH_SEND,
    PH_EOP,
    PH_JIDLE
  } phase_t;
endpackage

// File: rtl/tx_byte_feed.sv
module tx_byte_feed
  import pkt_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              hs_mode,
  input  logic [7:0]        hs_pid,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              active,
  input  logic              hs_q,
  input  logic              take,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic [BYTE_W-1:0] nxt_data,
  output logic              nxt_full
);
  logic [CNT_W-1:0] owed;
  logic [7:0]       pid_q;
  logic             give_sync;
  logic             fill_ok;
  logic             fill;

  assign fill_ok  = active && !nxt_full && (owed != '0);
  assign in_ready = fill_ok && !hs_q;
  assign fill     = fill_ok && (hs_q || in_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed      <= '0;
      pid_q     <= '0;
      give_sync <= 1'b0;
      nxt_data  <= '0;
      nxt_full  <= 1'b0;
    end else if (load) begin
      owed      <= hs_mode ? CNT_W'(2) : byte_count;
      pid_q     <= hs_pid;
      give_sync <= 1'b1;
      nxt_full  <= 1'b0;
    end else begin
      if (fill) begin
        if (hs_q) nxt_data <= give_sync ? SYNC_BYTE : pid_q;
        else      nxt_data <= in_data;
        nxt_full  <= 1'b1;
        owed      <= owed - 1'b1;
        give_sync <= 1'b0;
      end else if (take) begin
        nxt_full <= 1'b0;
      end
    end
  end

  AST_PREFETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_full && !take && !load) |=> $stable(nxt_data)) else $error("prefetch byte changed"); // R10
endmodule

// File: rtl/tx_bit_engine.sv
module tx_bit_engine
  import pkt_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prime,
  input  logic              step,
  input  logic [BYTE_W-1:0] nxt_data,
  input  logic              nxt_full,
  output logic              take,
  output logic              more,
  output logic              line_k
);
  localparam int SW = $clog2(STUFF_RUN + 1);
  localparam int BW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] cur;
  logic [BW-1:0]     bits_left;
  logic [SW-1:0]     run_left;
  logic              stuff_due;
  logic              bit_val;

  assign stuff_due = (run_left == '0);
  assign bit_val   = (bits_left == '0) ? nxt_data[0] : cur[0];
  assign more      = (bits_left != '0) || nxt_full;
  assign take      = step && !stuff_due && (bits_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= '0;
      bits_left <= '0;
      run_left  <= SW'(STUFF_RUN);
      line_k    <= 1'b0;
    end else if (prime) begin
      cur       <= '0;
      bits_left <= '0;
      run_left  <= SW'(STUFF_RUN);
      line_k    <= 1'b0;
    end else if (step) begin
      if (stuff_due) begin
        line_k   <= ~line_k;
        run_left <= SW'(STUFF_RUN);
      end else begin
        if (bits_left == '0) begin
          cur       <= {1'b0, nxt_data[BYTE_W-1:1]};
          bits_left <= BW'(BYTE_W - 1);
        end else begin
          cur       <= {1'b0, cur[BYTE_W-1:1]};
          bits_left <= bits_left - 1'b1;
        end
        if (!bit_val) begin
          line_k   <= ~line_k;
          run_left <= SW'(STUFF_RUN);
        end else begin
          run_left <= run_left - 1'b1;
        end
      end
    end
  end

  AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stuff_due) |=> (line_k != $past(line_k))) else $error("stuff slot did not toggle"); // R5
  AST_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> nxt_full) else $error("consumed empty prefetch"); // R3
endmodule

// File: rtl/tx_line_seq.sv
module tx_line_seq
  import pkt_tx_pkg::*;
#(
  parameter int CPB      = 8,
  parameter int EOP_BITS = 2,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs_mode,
  input  logic              more,
  input  logic              line_k,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic              accept,
  output logic              prime,
  output logic              step,
  output logic              active,
  output logic              hs_q,
  output logic              busy,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic [ADDR_W-1:0] dev_addr
);
  localparam int EOP_LEN = CPB * EOP_BITS;
  localparam int TICK_W  = $clog2(EOP_LEN + 1);

  phase_t            phase;
  logic [TICK_W-1:0] tick;
  logic [TICK_W-1:0] last;
  logic              slot_end;

  assign last     = (phase == PH_EOP) ? TICK_W'(EOP_LEN - 1) : TICK_W'(CPB - 1);
  assign slot_end = (phase inside {PH_ACQ, PH_SEND, PH_EOP, PH_JIDLE}) && (tick == last);
  assign active   = (phase == PH_ACQ) || (phase == PH_SEND);
  assign accept   = (phase == PH_IDLE) && start;
  assign prime    = (phase == PH_PRESET);
  assign step     = slot_end && active && more;
  assign busy     = (phase != PH_IDLE);

  assign oe = phase inside {PH_ACQ, PH_SEND, PH_EOP, PH_JIDLE};
  assign dp = (phase == PH_SEND) && line_k;
  assign dm = (phase inside {PH_PRESET, PH_ACQ, PH_JIDLE}) || ((phase == PH_SEND) && !line_k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      tick     <= '0;
      hs_q     <= 1'b0;
      dev_addr <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_PRESET;
            hs_q  <= hs_mode;
          end
        end
        PH_PRESET: begin
          phase <= PH_ACQ;
          tick  <= '0;
        end
        PH_ACQ, PH_SEND: begin
          if (slot_end) begin
            tick  <= '0;
            phase <= more ? PH_SEND : PH_EOP;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        PH_EOP: begin
          if (slot_end) begin
            tick  <= '0;
            phase <= PH_JIDLE;
            if (!hs_q) dev_addr <= pend_addr;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        PH_JIDLE: begin
          if (slot_end) begin
            tick  <= '0;
            phase <= PH_IDLE;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_J_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> ($past(dm) && !$past(dp))) else $error("drivers on without J preset"); // R2
  AST_ADDR_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_addr != $past(dev_addr)) |-> ($past(phase) == PH_EOP && !$past(hs_q))) else $error("address moved outside data EOP"); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (hs_q == $past(hs_q))) else $error("start taken while busy"); // R9
endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx
  import pkt_tx_pkg::*;
#(
  parameter int CPB       = 8,
  parameter int EOP_BITS  = 2,
  parameter int STUFF_RUN = 6,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs_mode,
  input  logic [7:0]        hs_pid,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              line_dp,
  output logic              line_dm,
  output logic              line_oe,
  output logic              busy
);
  logic              accept, prime, step, active, hs_q;
  logic              take, more, line_k, nxt_full;
  logic [BYTE_W-1:0] nxt_data;

  tx_line_seq #(.CPB(CPB), .EOP_BITS(EOP_BITS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode),
    .more(more), .line_k(line_k), .pend_addr(pend_addr),
    .accept(accept), .prime(prime), .step(step), .active(active),
    .hs_q(hs_q), .busy(busy), .dp(line_dp), .dm(line_dm), .oe(line_oe),
    .dev_addr(dev_addr)
  );

  tx_byte_feed #(.CNT_W(CNT_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .load(accept), .hs_mode(hs_mode),
    .hs_pid(hs_pid), .byte_count(byte_count), .active(active), .hs_q(hs_q),
    .take(take), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .nxt_data(nxt_data), .nxt_full(nxt_full)
  );

  tx_bit_engine #(.STUFF_RUN(STUFF_RUN)) u_bits (
    .clk(clk), .rst_n(rst_n), .prime(prime), .step(step),
    .nxt_data(nxt_data), .nxt_full(nxt_full),
    .take(take), .more(more), .line_k(line_k)
  );

  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !hs_q)) else $error("ready outside data packet"); // R10
endmodule

// File: tb/sim_ls_pkt_tx.sv
module sim_ls_pkt_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       hs_mode = 1'b0;
  logic [7:0] hs_pid = '0;
  logic [7:0] byte_count = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [6:0] pend_addr = '0;
  logic [6:0] dev_addr;
  logic       line_dp, line_dm, line_oe, busy;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] txb[$];
  logic [7:0] feed_q[$];

  always #5 clk = ~clk;

  ls_pkt_tx u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode), .hs_pid(hs_pid),
    .byte_count(byte_count), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pend_addr(pend_addr), .dev_addr(dev_addr),
    .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] s, input string t);
    exp_q.push_back(s);
    tag_q.push_back(t);
  endtask

  // reference model: {oe,dp,dm} per slot
  task automatic build_model(input string dtag);
    logic line = 1'b0;
    int   run  = 6;
    push(3'b101, "R2");
    foreach (txb[b]) begin
      for (int k = 0; k < 8; k++) begin
        if (run == 0) begin
          line = ~line;
          run  = 6;
          push(line ? 3'b110 : 3'b101, "R5");
        end
        if (!txb[b][k]) begin
          line = ~line;
          run  = 6;
        end else begin
          run--;
        end
        push(line ? 3'b110 : 3'b101, dtag);
      end
    end
    push(3'b100, "R6");
    push(3'b100, "R6");
    push(3'b101, "R6");
    push(3'b000, "R6");
  endtask

  // monitor: samples mid-slot, compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (line_oe) begin
        repeat (3) @(negedge clk);
        forever begin
          logic [2:0] got, want;
          string t;
          got = {line_oe, line_dp, line_dm};
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected slot", got, 0);
            break;
          end
          want = exp_q.pop_front();
          t    = tag_q.pop_front();
          chk(got == want, t, got, want);
          if (want == 3'b000) break;
          repeat (8) @(negedge clk);
        end
      end
    end
  end

  task automatic feeder(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      logic r;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = feed_q[i];
      forever begin
        r = in_ready;
        @(posedge clk);
        @(negedge clk);
        if (r) break;
      end
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic run_pkt(input bit hs, input logic [7:0] pid, input int cnt,
                         input int supply, input int gap, input bit poke, input string dtag);
    int ready_seen = 0;
    int cyc = 0;
    txb.delete();
    if (hs) begin
      txb.push_back(8'h80);
      txb.push_back(pid);
    end else begin
      for (int i = 0; i < supply; i++) txb.push_back(feed_q[i]);
    end
    build_model(dtag);
    fork
      begin
        if (!hs) feeder(supply, gap);
      end
      begin
        @(negedge clk);
        hs_mode    = hs;
        hs_pid     = pid;
        byte_count = 8'(cnt);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !line_oe && line_dm && !line_dp, "R2 preset J before drive",
            {busy, line_oe, line_dp, line_dm}, 4'b1001);
        @(negedge clk);
        chk(line_oe == 1'b1, "R1 drive one clock after accept", line_oe, 1);
        while (busy) begin
          if (in_ready) ready_seen++;
          cyc++;
          if (poke && cyc == 30) begin
            hs_mode = ~hs;
            start   = 1'b1;
          end
          if (poke && cyc == 31) start = 1'b0;
          @(negedge clk);
        end
      end
    join
    if (hs) chk(ready_seen == 0, "R7 no stream ready in handshake", ready_seen, 0);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !line_oe && !line_dp && !line_dm && !in_ready, "R9 reset idle",
        {busy, line_oe, line_dp, line_dm, in_ready}, 0);
    chk(dev_addr == 7'h00, "R8 reset address", dev_addr, 0);

    pend_addr = 7'h2A;
    run_pkt(1'b1, 8'hD2, 0, 0, 0, 1'b0, "R7");
    chk(dev_addr == 7'h00, "R8 handshake keeps address", dev_addr, 0);

    feed_q = '{8'h80, 8'hC3, 8'h01};
    run_pkt(1'b0, 8'h00, 3, 3, 0, 1'b0, "R4");
    chk(dev_addr == 7'h2A, "R8 data commits address", dev_addr, 7'h2A);

    feed_q = '{8'h80, 8'h3F, 8'hFC};
    run_pkt(1'b0, 8'h00, 3, 3, 0, 1'b0, "R5");

    pend_addr = 7'h15;
    feed_q = '{8'h80, 8'hFF, 8'hFF, 8'h55};
    run_pkt(1'b0, 8'h00, 4, 4, 7, 1'b0, "R10");
    chk(dev_addr == 7'h15, "R8 second data commit", dev_addr, 7'h15);

    pend_addr = 7'h33;
    run_pkt(1'b1, 8'h5A, 0, 0, 0, 1'b1, "R9");
    chk(dev_addr == 7'h15, "R8 NAK keeps address", dev_addr, 7'h15);
    repeat (20) @(negedge clk);
    chk(!busy, "R9 start while busy not queued", busy, 0);

    feed_q = '{8'h80, 8'hA5};
    run_pkt(1'b0, 8'h00, 4, 2, 0, 1'b0, "R11");
    chk(!in_ready, "R11 ready low after truncation", in_ready, 0);

    feed_q = '{8'h80, 8'h00, 8'h7E};
    run_pkt(1'b0, 8'h00, 3, 3, 2, 1'b0, "R3");

    chk(exp_q.size() == 0, "R1 all slots observed", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule